// File: doc/BRIEF.md
# Prescaled PWM Channel

This block is one pulse-width modulator channel with three software-visible registers: a control word (clock prescale and stop mode), a duty word (on-time count plus a force-high flag) and a period word. An input clock drives the channel, and an enable input starts and stops it. The input clock is divided by (prescale + 1) to give a count tick. A period counter runs from zero up to the period value on those ticks. The output is high while that counter is below the duty value.

Writes to the registers land at once and read back at once. The counter, however, works from a snapshot of the three settings that it takes when it starts and again at every period boundary, so a change never cuts a period short. Dropping the enable either kills the period on the next clock or lets it run to its end, as the stop-mode bit selects.

Top module: `pwm_chan_top`

## Requirements
- R1: After reset all three registers read zero, the channel is idle and the output is low.
- R2: Word address 0 holds prescale in bits [5:0] and stop-mode in bit 6. Word address 1 holds duty in bits [9:0] and the force-high flag in bit 10. Word address 2 holds the period value in bits [9:0]. Each reads back the last value written, unused bits read zero, and word address 3 reads zero.
- R3: While enabled, one output period lasts (prescale+1)*(period+1) clocks. The output is high for the first duty*(prescale+1) clocks of it and low for the rest.
- R4: A duty value of 0 gives a constant low output. A duty value greater than the period value gives a constant high output.
- R5: With the force-high flag set, the output stays high for the whole period whatever the duty value.
- R6: Prescale, duty and period values written while the channel runs take effect only from the start of the next period.
- R7: With stop-mode 0, dropping the enable lets the current period finish unchanged. After that the output stays low.
- R8: With stop-mode 1, dropping the enable ends the period at the next clock edge and forces the output low.
- R9: While idle the output is low. Raising the enable starts a fresh period from count zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel run request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 11 | Write data |
| rdata | output | 11 | Read data for addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench compares the output on every clock against a pattern computed from the settings. A wrong divider, or an off-by-one in the period or the compare, therefore shows up as a shifted edge. It covers duty at zero, duty above the period value, the force-high flag, and the largest period value, where a counter that wraps early would cut a clock from the high time. Register writes made in the middle of a period must leave the rest of that period untouched; a design without the snapshot would change the output at once. The two stop modes are told apart by dropping the enable in mid-period: a graceful stop that quits early, or an abrupt stop that waits, each leaves the wrong number of high clocks.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PSC_W_DEF = 6;
  localparam int CNT_W_DEF = 10;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_PER  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int PSC_W  = PSC_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int DATA_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PSC_W-1:0]  psc_q,
  output logic              abrupt_q,
  output logic [CNT_W-1:0]  dc_q,
  output logic              full_q,
  output logic [CNT_W-1:0]  pv_q
);
  localparam int CTRL_W = PSC_W + 1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W:0]    duty_q, duty_d;
  logic [CNT_W-1:0]  per_q, per_d;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    ctrl_d = ctrl_q;
    duty_d = duty_q;
    per_d  = per_q;
    if (wr_en) begin
      unique case (sel)
        SEL_CTRL: ctrl_d = wdata[CTRL_W-1:0];
        SEL_DUTY: duty_d = wdata[CNT_W:0];
        SEL_PER:  per_d  = wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      duty_q <= duty_d;
      per_q  <= per_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
      SEL_DUTY: rdata[CNT_W:0]    = duty_q;
      SEL_PER:  rdata[CNT_W-1:0]  = per_q;
      default:  rdata = '0;
    endcase
  end

  assign psc_q    = ctrl_q[PSC_W-1:0];
  assign abrupt_q = ctrl_q[PSC_W];
  assign dc_q     = duty_q[CNT_W-1:0];
  assign full_q   = duty_q[CNT_W];
  assign pv_q     = per_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] limit,
  output logic [PSC_W-1:0] cnt,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_d;
  logic             cnt_en;

  assign tick   = run && (cnt == limit);
  assign cnt_en = run || clr;

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/pwm_period_ctl.sv
module pwm_period_ctl #(
  parameter int PSC_W = 6,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             abrupt_mode,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc_reg,
  input  logic [CNT_W-1:0] dc_reg,
  input  logic             full_reg,
  input  logic [CNT_W-1:0] pv_reg,
  output logic             running,
  output logic             start,
  output logic             abrupt_stop,
  output logic             period_end,
  output logic [CNT_W-1:0] cnt,
  output logic [PSC_W-1:0] psc_act,
  output logic [CNT_W-1:0] dc_act,
  output logic             full_act,
  output logic [CNT_W-1:0] pv_act
);
  logic             run_d;
  logic [CNT_W-1:0] cnt_d;
  logic             load;

  assign start       = !running && chan_en;
  assign abrupt_stop = running && !chan_en && abrupt_mode;
  assign period_end  = running && tick && (cnt == pv_act);
  assign load        = start || (period_end && chan_en && !abrupt_stop);

  always_comb begin
    run_d = running;
    cnt_d = cnt;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (abrupt_stop) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (period_end) begin
      cnt_d = '0;
      run_d = chan_en;
    end else if (running && tick) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      running <= run_d;
      cnt     <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act  <= '0;
      dc_act   <= '0;
      full_act <= 1'b0;
      pv_act   <= '0;
    end else if (load) begin
      psc_act  <= psc_reg;
      dc_act   <= dc_reg;
      full_act <= full_reg;
      pv_act   <= pv_reg;
    end
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 10
) (
  input  logic             running,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] dc_act,
  input  logic             full_act,
  output logic             pwm_out
);
  always_comb begin
    pwm_out = running && (full_act || (cnt < dc_act));
  end
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
  import pwm_pkg::*;
#(
  parameter int PSC_W  = PSC_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int DATA_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic [PSC_W-1:0] psc_q, psc_act, psc_cnt;
  logic [CNT_W-1:0] dc_q, pv_q, dc_act, pv_act, cnt_q;
  logic             abrupt_q, full_q, full_act;
  logic             run_q, start, abrupt_stop, period_end, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  pwm_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .psc_q(psc_q), .abrupt_q(abrupt_q), .dc_q(dc_q),
    .full_q(full_q), .pv_q(pv_q)
  );

  pwm_prescaler #(.PSC_W(PSC_W)) psc_i (
    .clk(clk), .rst_n(rst_sync_n), .run(run_q), .clr(start || abrupt_stop),
    .limit(psc_act), .cnt(psc_cnt), .tick(tick)
  );

  pwm_period_ctl #(.PSC_W(PSC_W), .CNT_W(CNT_W)) per_i (
    .clk(clk), .rst_n(rst_sync_n), .chan_en(chan_en), .abrupt_mode(abrupt_q),
    .tick(tick), .psc_reg(psc_q), .dc_reg(dc_q), .full_reg(full_q),
    .pv_reg(pv_q), .running(run_q), .start(start), .abrupt_stop(abrupt_stop),
    .period_end(period_end), .cnt(cnt_q), .psc_act(psc_act), .dc_act(dc_act),
    .full_act(full_act), .pv_act(pv_act)
  );

  pwm_compare #(.CNT_W(CNT_W)) cmp_i (
    .running(run_q), .cnt(cnt_q), .dc_act(dc_act), .full_act(full_act),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int PSC_W = 6,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             abrupt_mode,
  input logic             running,
  input logic             period_end,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] pv_act,
  input logic [CNT_W-1:0] dc_act,
  input logic [PSC_W-1:0] pcnt,
  input logic [PSC_W-1:0] psc_act,
  input logic             pwm_out
);
  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pwm_out); // R9
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= pv_act)); // R3
  AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pcnt <= psc_act)); // R3
  AST_ABRUPT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !chan_en && abrupt_mode) |=> !running); // R8
  AST_GRACEFUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !chan_en && !abrupt_mode && !period_end) |=> running); // R7
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_end) |=> $stable(dc_act) && $stable(pv_act)); // R6
endmodule

bind pwm_chan_top pwm_chan_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .chan_en(chan_en), .abrupt_mode(abrupt_q),
  .running(run_q), .period_end(period_end), .cnt(cnt_q), .pv_act(pv_act),
  .dc_act(dc_act), .pcnt(psc_cnt), .psc_act(psc_act), .pwm_out(pwm_out)
);

// File: tb/pwm_chan_top_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_top_tb_top;
  localparam real CLK_P = 4.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_en;
  logic        wr_en;
  logic [1:0]  addr;
  logic [10:0] wdata;
  logic [10:0] rdata;
  logic        pwm_out;

  int n_chk  = 0;
  int n_fail = 0;

  pwm_chan_top dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit exp_out(int j, int p, int pv, int dc, bit full);
    int c;
    c = (j / (p + 1)) % (pv + 1);
    return full || (c < dc);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Each span call is one check: every sample over n clocks must match.
  task automatic span(string req, int n, int base, int p, int pv, int dc, bit full);
    int bad = 0;
    int first_k = -1;
    int first_a = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_out != exp_out(base + k, p, pv, dc, full)) begin
        if (bad == 0) begin first_k = k; first_a = pwm_out; end
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: sample %0d actual %0d expected %0d", req, first_k,
               first_a, !first_a);
    end
  endtask

  task automatic span_low(string req, int n);
    span(req, n, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic do_reset();
    chan_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = 2'(a); wdata = 11'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, int a, int exp);
    addr = 2'(a);
    #1;
    check(req, int'(rdata), exp);
  endtask

  task automatic setup(int p, bit abrupt, int dc, bit full, int pv);
    do_reset();
    wr(0, (int'(abrupt) << 6) | p);
    wr(1, (int'(full) << 10) | dc);
    wr(2, pv);
  endtask

  task automatic t_reset();
    do_reset();
    rd_check("R1 ctrl", 0, 0);
    rd_check("R1 duty", 1, 0);
    rd_check("R1 period", 2, 0);
    check("R1 out", int'(pwm_out), 0);
  endtask

  task automatic t_readback();
    do_reset();
    wr(0, 11'h7FF);
    wr(1, 11'h7FF);
    wr(2, 11'h7FF);
    wr(3, 11'h7FF);
    rd_check("R2 ctrl", 0, 'h7F);
    rd_check("R2 duty", 1, 'h7FF);
    rd_check("R2 period", 2, 'h3FF);
    rd_check("R2 hole", 3, 0);
    wr(0, 'h25);
    rd_check("R2 ctrl rewrite", 0, 'h25);
  endtask

  task automatic t_run(string req, int p, int pv, int dc, bit full, int n);
    setup(p, 1'b0, dc, full, pv);
    chan_en = 1'b1;
    span(req, n, 0, p, pv, dc, full);
    chan_en = 1'b0;
  endtask

  task automatic t_deferred();
    setup(0, 1'b0, 2, 1'b0, 7);
    chan_en = 1'b1;
    span("R6 before", 4, 0, 0, 7, 2, 1'b0);
    wr_en = 1'b1; addr = 2'd1; wdata = 11'd4;
    span("R6 after duty write", 1, 4, 0, 7, 2, 1'b0);
    wr_en = 1'b1; addr = 2'd2; wdata = 11'd5;
    span("R6 after period write", 1, 5, 0, 7, 2, 1'b0);
    wr_en = 1'b1; addr = 2'd0; wdata = 11'd1;
    span("R6 old period tail", 2, 6, 0, 7, 2, 1'b0);
    span("R6 new settings", 24, 0, 1, 5, 4, 1'b0);
    chan_en = 1'b0;
  endtask

  task automatic t_graceful();
    setup(1, 1'b0, 3, 1'b0, 3);
    chan_en = 1'b1;
    span("R7 running", 2, 0, 1, 3, 3, 1'b0);
    chan_en = 1'b0;
    span("R7 finishes period", 6, 2, 1, 3, 3, 1'b0);
    span_low("R7 low after end", 10);
    chan_en = 1'b1;
    span("R9 fresh start", 16, 0, 1, 3, 3, 1'b0);
    chan_en = 1'b0;
  endtask

  task automatic t_abrupt();
    setup(1, 1'b1, 3, 1'b0, 3);
    chan_en = 1'b1;
    span("R8 running", 2, 0, 1, 3, 3, 1'b0);
    chan_en = 1'b0;
    span_low("R8 immediate low", 10);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    span_low("R9 idle low", 8);
    t_run("R3 p0", 0, 9, 3, 1'b0, 30);
    t_run("R3 p2", 2, 4, 2, 1'b0, 45);
    t_run("R4 zero duty", 1, 5, 0, 1'b0, 24);
    t_run("R4 duty above period", 0, 5, 9, 1'b0, 18);
    t_run("R5 force high", 2, 3, 0, 1'b1, 24);
    t_run("R3 max period", 0, 1023, 1023, 1'b0, 2048);
    t_deferred();
    t_graceful();
    t_abrupt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule